// File: doc/BRIEF.md
# Pulse-Train Cycle Type Selector

This block chooses, one cycle ahead, what the next switching cycle of a primary-side flyback controller will be. A full-energy power cycle is the default. A short sense cycle delivers a sixteenth of the energy and still returns a voltage reading. A skipped cycle keeps the gate off for a whole period. Regulation does not come from changing pulse width or frequency. It comes from the choice of cycle type. Each decision uses only the comparator reading taken at the end of the cycle that is just finishing.

At every cycle boundary the surrounding controller pulses `cyc_end`. In the same clock it presents three values: the comparator result (auxiliary voltage above the reference or not), and the on-time and period that were measured for the cycle now ending. The selector registers the type of the coming cycle. It also gives the gate timer its on-time and period targets. Power cycles reuse the latest measured power geometry. Sense cycles run a quarter of that on-time over the same period. When readings stay high for a long stretch without any power cycle, the selector enters a light-load mode. In that mode, sense cycles are interleaved with a run of skipped cycles, and the length of the run adapts to each reading.

Top module: `ptc_cycle_selector`

## Requirements
- R1: After reset, the cycle type is power (code 0), the on-time target is DEF_ON (200) and the period target is DEF_PERIOD (400).
- R2: Type codes on `cyc_type` are: 0 power, 1 sense, 2 skip. Outside skip mode, the type chosen at the end of a power or sense cycle is sense when `fb_high` is 1 and power when it is 0. The one exception is skip entry (R6).
- R3: During a sense cycle, the on-time target is the stored power on-time divided by four, rounded down. The period target is the stored power period.
- R4: During a skip cycle, the on-time target is 0 and the period target is the stored power period.
- R5: `meas_on` and `meas_period` are stored only at the end of a power cycle. During a power cycle, the targets equal the values stored at the most recent power-cycle end.
- R6: Outside skip mode, consecutive sense cycles that end high are counted, and any power cycle clears the count. The end that brings this count to QUIET_LIMIT (8) enters skip mode with depth 1, and the next cycle is a skip.
- R7: In skip mode, a sense cycle that ends high raises the depth by one, saturating at 15. It is followed by exactly that many skip cycles and then a sense cycle.
- R8: In skip mode, a sense cycle that ends low at depth d>0 lowers the depth to d-1. It is followed by d-1 skip cycles and then a sense cycle; when d-1 is 0, no skip cycles come between.
- R9: In skip mode, a sense cycle that ends low at depth 0 leaves skip mode, and the next cycle is power. Re-entry needs a fresh run of QUIET_LIMIT high sense endings.
- R10: `fb_high` is ignored at the end of a skip cycle. No skip ever leads directly to a power cycle.
- R11: Type and targets change only on the clock edge where `cyc_end` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cyc_end | input | 1 | One-clock strobe marking the end of the current switching cycle |
| fb_high | input | 1 | Comparator result sampled near the end of the off period, valid with `cyc_end` |
| meas_on | input | TW | Measured on-time of the ending cycle, valid with `cyc_end` |
| meas_period | input | TW | Measured period of the ending cycle, valid with `cyc_end` |
| cyc_type | output | 2 | Type of the current/next cycle: 0 power, 1 sense, 2 skip |
| on_target | output | TW | On-time target for the gate timer |
| period_target | output | TW | Period target for the gate timer |

## Verification
The assertions assume that `cyc_end` is a single-clock pulse. They also assume that `fb_high` and the measured durations matter only in the clock where the strobe is high. The assertions further assume that no strobe arrives while the internal reset synchroniser is still holding the logic in reset. The stimulus therefore waits several clocks after reset release. It always drops the strobe after one clock and separates strobes by zero to three idle clocks. It randomises `fb_high` and the measured durations even at the ends of skip and sense cycles, where those inputs must have no effect.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  typedef enum logic [1:0] {
    CYC_POWER = 2'd0,
    CYC_SENSE = 2'd1,
    CYC_SKIP  = 2'd2
  } cyc_kind_e;
endpackage

// File: rtl/ptc_rst_sync.sv
module ptc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = chain_q[STAGES-1];
endmodule

// File: rtl/ptc_skip_ctrl.sv
module ptc_skip_ctrl
  import ptc_pkg::*;
#(
  parameter int DEPTH_W     = 4,
  parameter int QUIET_LIMIT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cyc_end,
  input  logic               fb_high,
  output cyc_kind_e          cur_type,
  output logic               skip_mode,
  output logic [DEPTH_W-1:0] skip_depth
);
  localparam int QW = $clog2(QUIET_LIMIT + 1);
  localparam logic [DEPTH_W-1:0] DEPTH_MAX = {DEPTH_W{1'b1}};
  localparam logic [DEPTH_W-1:0] DEPTH_ONE = DEPTH_W'(1);
  localparam logic [QW-1:0] QUIET_LAST = QW'(QUIET_LIMIT - 1);

  cyc_kind_e          type_q, type_d;
  logic               skip_q, skip_d;
  logic [DEPTH_W-1:0] depth_q, depth_d;
  logic [DEPTH_W-1:0] left_q, left_d;
  logic [QW-1:0]      quiet_q, quiet_d;
  logic [DEPTH_W-1:0] dep_up, dep_dn;

  assign dep_up = (depth_q == DEPTH_MAX) ? DEPTH_MAX : depth_q + DEPTH_ONE;
  assign dep_dn = depth_q - DEPTH_ONE;

  always_comb begin
    type_d  = type_q;
    skip_d  = skip_q;
    depth_d = depth_q;
    left_d  = left_q;
    quiet_d = quiet_q;
    unique case (type_q)
      CYC_SKIP: begin
        if (left_q != '0) begin
          type_d = CYC_SKIP;
          left_d = left_q - DEPTH_ONE;
        end else begin
          type_d = CYC_SENSE;
        end
      end
      CYC_POWER: begin
        quiet_d = '0;
        type_d  = fb_high ? CYC_SENSE : CYC_POWER;
      end
      default: begin
        if (skip_q) begin
          if (fb_high) begin
            depth_d = dep_up;
            type_d  = CYC_SKIP;
            left_d  = dep_up - DEPTH_ONE;
          end else if (depth_q == '0) begin
            skip_d  = 1'b0;
            quiet_d = '0;
            type_d  = CYC_POWER;
          end else begin
            depth_d = dep_dn;
            if (dep_dn != '0) begin
              type_d = CYC_SKIP;
              left_d = dep_dn - DEPTH_ONE;
            end else begin
              type_d = CYC_SENSE;
            end
          end
        end else if (fb_high) begin
          if (quiet_q == QUIET_LAST) begin
            skip_d  = 1'b1;
            depth_d = DEPTH_ONE;
            left_d  = '0;
            quiet_d = '0;
            type_d  = CYC_SKIP;
          end else begin
            quiet_d = quiet_q + QW'(1);
            type_d  = CYC_SENSE;
          end
        end else begin
          type_d = CYC_POWER;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q  <= CYC_POWER;
      skip_q  <= 1'b0;
      depth_q <= '0;
      left_q  <= '0;
      quiet_q <= '0;
    end else if (cyc_end) begin
      type_q  <= type_d;
      skip_q  <= skip_d;
      depth_q <= depth_d;
      left_q  <= left_d;
      quiet_q <= quiet_d;
    end
  end

  assign cur_type   = type_q;
  assign skip_mode  = skip_q;
  assign skip_depth = depth_q;
endmodule

// File: rtl/ptc_target.sv
module ptc_target
  import ptc_pkg::*;
#(
  parameter int TW         = 16,
  parameter int DEF_ON     = 200,
  parameter int DEF_PERIOD = 400
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_end,
  input  cyc_kind_e     cur_type,
  input  logic [TW-1:0] meas_on,
  input  logic [TW-1:0] meas_period,
  output logic [TW-1:0] on_target,
  output logic [TW-1:0] period_target
);
  logic [TW-1:0] on_q, on_d, per_q, per_d;
  logic          latch_en;

  assign latch_en = cyc_end && (cur_type == CYC_POWER);

  always_comb begin
    on_d  = meas_on;
    per_d = meas_period;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q  <= TW'(DEF_ON);
      per_q <= TW'(DEF_PERIOD);
    end else if (latch_en) begin
      on_q  <= on_d;
      per_q <= per_d;
    end
  end

  always_comb begin
    unique case (cur_type)
      CYC_POWER: on_target = on_q;
      CYC_SENSE: on_target = {2'b00, on_q[TW-1:2]};
      default:   on_target = '0;
    endcase
  end

  assign period_target = per_q;
endmodule

// File: rtl/ptc_cycle_selector.sv
module ptc_cycle_selector
  import ptc_pkg::*;
#(
  parameter int TW          = 16,
  parameter int DEPTH_W     = 4,
  parameter int QUIET_LIMIT = 8,
  parameter int DEF_ON      = 200,
  parameter int DEF_PERIOD  = 400
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_end,
  input  logic          fb_high,
  input  logic [TW-1:0] meas_on,
  input  logic [TW-1:0] meas_period,
  output logic [1:0]    cyc_type,
  output logic [TW-1:0] on_target,
  output logic [TW-1:0] period_target
);
  logic               rst_n_s;
  cyc_kind_e          cur_type;
  logic               skip_mode;
  logic [DEPTH_W-1:0] skip_depth;

  ptc_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  ptc_skip_ctrl #(.DEPTH_W(DEPTH_W), .QUIET_LIMIT(QUIET_LIMIT)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .cyc_end    (cyc_end),
    .fb_high    (fb_high),
    .cur_type   (cur_type),
    .skip_mode  (skip_mode),
    .skip_depth (skip_depth)
  );

  ptc_target #(.TW(TW), .DEF_ON(DEF_ON), .DEF_PERIOD(DEF_PERIOD)) u_tgt (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .cyc_end       (cyc_end),
    .cur_type      (cur_type),
    .meas_on       (meas_on),
    .meas_period   (meas_period),
    .on_target     (on_target),
    .period_target (period_target)
  );

  assign cyc_type = cur_type;
endmodule

// File: rtl/ptc_checker.sv
module ptc_checker #(
  parameter int TW      = 16,
  parameter int DEPTH_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cyc_end,
  input logic               fb_high,
  input logic [TW-1:0]      meas_on,
  input logic [TW-1:0]      meas_period,
  input logic [1:0]         cyc_type,
  input logic [TW-1:0]      on_target,
  input logic [TW-1:0]      period_target,
  input logic               skip_mode,
  input logic [DEPTH_W-1:0] skip_depth
);
  localparam logic [1:0] K_POWER = 2'd0;
  localparam logic [1:0] K_SENSE = 2'd1;
  localparam logic [1:0] K_SKIP  = 2'd2;

  // R2
  legal_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_type != 2'd3);

  // R2
  normal_decide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end && !skip_mode && cyc_type != K_SKIP && !fb_high |=> cyc_type == K_POWER);

  // R3
  power_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end && cyc_type == K_POWER |=>
      period_target == $past(meas_period) && (cyc_type != K_POWER || on_target == $past(meas_on)));

  // R4
  skip_gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_type == K_SKIP |-> on_target == '0);

  // R5
  hold_geom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end && cyc_type != K_POWER |=> $stable(period_target));

  // R7
  depth_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end && skip_mode && cyc_type == K_SENSE && fb_high |=>
      cyc_type == K_SKIP && skip_depth >= $past(skip_depth) && skip_depth != '0);

  // R9
  skip_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end && skip_mode && cyc_type == K_SENSE && !fb_high && skip_depth == '0 |=>
      cyc_type == K_POWER && !skip_mode);

  // R10
  skip_no_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end && cyc_type == K_SKIP |=> cyc_type != K_POWER);

  // R11
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_end |=> $stable(cyc_type) && $stable(on_target) && $stable(period_target));
endmodule

bind ptc_cycle_selector ptc_checker #(.TW(TW), .DEPTH_W(DEPTH_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cyc_end       (cyc_end),
  .fb_high       (fb_high),
  .meas_on       (meas_on),
  .meas_period   (meas_period),
  .cyc_type      (cyc_type),
  .on_target     (on_target),
  .period_target (period_target),
  .skip_mode     (skip_mode),
  .skip_depth    (skip_depth)
);

// File: tb/ptc_cycle_selector_tb.sv
module ptc_cycle_selector_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 16;
  localparam int QL = 8;
  localparam int DMAX = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_end = 1'b0;
  logic fb_high = 1'b0;
  logic [TW-1:0] meas_on = '0;
  logic [TW-1:0] meas_period = '0;
  logic [1:0] cyc_type;
  logic [TW-1:0] on_target, period_target;

  int n_checks = 0;
  int n_fail = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  // behavioural reference
  int m_type, m_on, m_per, m_skip, m_depth, m_quiet;
  int pend[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ptc_cycle_selector #(.TW(TW), .QUIET_LIMIT(QL)) u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_end(cyc_end), .fb_high(fb_high),
    .meas_on(meas_on), .meas_period(meas_period),
    .cyc_type(cyc_type), .on_target(on_target), .period_target(period_target)
  );

  task automatic plan_skips(int d);
    m_type = 2;
    for (int i = 1; i < d; i++) pend.push_back(2);
    pend.push_back(1);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_type = 0; m_on = 200; m_per = 400; m_skip = 0; m_depth = 0; m_quiet = 0;
      pend.delete();
    end else if (cyc_end) begin
      if (m_type == 0) begin
        m_on = int'(meas_on); m_per = int'(meas_period); m_quiet = 0;
      end
      if (m_type == 2) begin
        m_type = pend.pop_front();
      end else if (m_skip == 0) begin
        if (fb_high) begin
          if (m_type == 1) m_quiet++;
          if (m_type == 1 && m_quiet == QL) begin
            m_skip = 1; m_depth = 1; m_quiet = 0; plan_skips(1);
          end else m_type = 1;
        end else m_type = 0;
      end else begin
        if (fb_high) begin
          m_depth = (m_depth < DMAX) ? m_depth + 1 : DMAX;
          plan_skips(m_depth);
        end else if (m_depth == 0) begin
          m_skip = 0; m_type = 0;
        end else begin
          m_depth--;
          if (m_depth > 0) plan_skips(m_depth); else m_type = 1;
        end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R11: compared against the reference on every clock
  always @(negedge clk) begin
    if (rst_n && cmp_en && !done) begin
      chk(m_type == 2 ? "R4 type per-clock R11" : (m_type == 1 ? "R3 type per-clock R11" : "R2 type per-clock R11"),
          int'(cyc_type), m_type);
      chk("R3 on_target per-clock R11", int'(on_target),
          m_type == 0 ? m_on : (m_type == 1 ? m_on / 4 : 0));
      chk("R5 period_target per-clock R11", int'(period_target), m_per);
    end
  end

  task automatic cyc(bit fb, int on_v, int per_v, int idle = 2);
    @(negedge clk);
    cyc_end = 1'b1; fb_high = fb; meas_on = TW'(on_v); meas_period = TW'(per_v);
    @(negedge clk);
    cyc_end = 1'b0; fb_high = $urandom_range(0, 1); meas_on = TW'($urandom); meas_period = TW'($urandom);
    repeat (idle) @(negedge clk);
  endtask

  task automatic count_skips(output int n);
    n = 0;
    while (cyc_type == 2'd2 && n < 64) begin
      n++;
      cyc($urandom_range(0, 1), $urandom_range(0, 999), $urandom_range(0, 999));
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_en = 1'b1;
    // R1
    chk("R1 type", int'(cyc_type), 0);
    chk("R1 on", int'(on_target), 200);
    chk("R1 period", int'(period_target), 400);

    cyc(0, 120, 300);
    chk("R2 low->power", int'(cyc_type), 0);
    chk("R5 power on latched", int'(on_target), 120);
    cyc(1, 130, 320);
    chk("R2 high->sense", int'(cyc_type), 1);
    chk("R3 quarter on", int'(on_target), 32);
    chk("R3 same period", int'(period_target), 320);
    cyc(0, 999, 999);
    chk("R5 sense meas ignored", int'(on_target), 130);
    chk("R5 sense meas ignored per", int'(period_target), 320);

    // R6 entry
    cyc(1, 200, 500, 0);
    for (int i = 0; i < QL - 1; i++) cyc(1, 7, 7, i % 3);
    chk("R6 not yet", int'(cyc_type), 1);
    cyc(1, 7, 7);
    chk("R6 enter skip", int'(cyc_type), 2);
    chk("R4 skip on zero", int'(on_target), 0);
    chk("R4 skip period", int'(period_target), 500);
    count_skips(n);
    chk("R7 first depth", n, 1);
    chk("R10 skip ends in sense", int'(cyc_type), 1);

    for (int d = 2; d <= DMAX + 2; d++) begin
      cyc(1, 5, 5, 1);
      count_skips(n);
      chk("R7 skips after high", n, (d < DMAX) ? d : DMAX);
    end
    for (int d = DMAX - 1; d >= 1; d--) begin
      cyc(0, 5, 5, 1);
      count_skips(n);
      chk("R8 skips after low", n, d);
    end
    cyc(0, 5, 5);
    chk("R8 depth to zero sense", int'(cyc_type), 1);
    cyc(0, 5, 5);
    chk("R9 exit to power", int'(cyc_type), 0);
    chk("R9 power geometry", int'(on_target), 200);

    cyc(1, 80, 240);
    for (int i = 0; i < QL - 1; i++) cyc(1, 3, 3);
    chk("R9 count restarted", int'(cyc_type), 1);
    cyc(1, 3, 3);
    chk("R9 re-entry", int'(cyc_type), 2);
    count_skips(n);

    // random patterns, checked every clock against the reference
    for (int i = 0; i < 600; i++) begin
      bit fb;
      fb = (i % 200 < 120) ? ($urandom_range(0, 3) != 0) : ($urandom_range(0, 3) == 0);
      cyc(fb, $urandom_range(0, 4000), $urandom_range(0, 8000), $urandom_range(0, 3));
    end
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule